// File: doc/BRIEF.md
# Byte-Buffered Two-Wire Bus Slave Port

This block is a two-wire (I2C) bus slave that serves a processor through a small register window. It watches the serial clock and data lines on the system clock, finds start and stop conditions, and compares the first byte after a start with its own 7-bit address. On a match it acknowledges. Depending on the direction bit, it then takes in bytes from the bus master into a one-byte buffer, or sends bytes that software has placed in that buffer.

Software sees three registers. The control register has two sticky error flags, a port-enable bit, a clock-release bit and a 4-bit mode code. The data buffer is the second register, and a status register holds a buffer-full bit. The port stretches the bus clock by pulling SCL low whenever the clock-release bit is clear. After it has acknowledged a read address, and after each byte it transmits, the port clears that bit itself, so the master waits until software has loaded the next byte. One interrupt line gives a single-cycle pulse for each finished byte. In one mode it also pulses for every start and stop condition.

Top module: `i2cs_port`

## Requirements
- R1: After reset the control, data and status registers read 0x00, neither line is pulled low and `irq` is low.
- R2: With the port-enable bit (control bit 5) clear, both lines stay released and bus traffic is ignored: no acknowledge and no interrupt.
- R3: Control fields: bit 7 write-collision flag, bit 6 receive-overflow flag, bit 5 enable, bit 4 clock release, bits 3..0 mode. Writing 0 to a flag clears it. Writing 1 leaves it unchanged and can never set it.
- R4: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. In mode 4'b1110 each start and each stop gives one interrupt pulse. Mode 4'b0110 gives none for them.
- R5: When the first byte after a start carries the own address in bits 7..1, the port pulls SDA low during the ninth clock. For any other address it stays off the bus until the next start.
- R6: In write direction (bit 0 = 0), each received byte is acknowledged and placed in the data register (address 1), and the buffer-full bit (status address 2, bit 0) is set. Reading the data register clears that bit.
- R7: A byte that completes while the buffer is full sets the overflow flag and is not acknowledged. The buffer keeps the earlier byte.
- R8: In read direction (bit 0 = 1), the port clears the clock-release bit and holds SCL low after the address acknowledge and after every byte the master acknowledges. Setting the bit sends the buffer MSB first.
- R9: A data-register write while a byte is being shifted out sets the write-collision flag and is dropped. Data writes in receive direction never set it.
- R10: `irq` is a one-cycle pulse after the ninth clock of each handled byte: a matched address, a received byte, or a transmitted byte.
- R11: Mode codes other than 4'b0110 and 4'b1110 (10-bit codes 4'b0111 and 4'b1111 included) leave the port off the bus.
- R12: In an active slave mode, clearing the clock-release bit holds SCL low and setting it releases SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register empties it |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Single-cycle interrupt pulse |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| scl_oe | output | 1 | Pull SCL low when high (open-drain enable) |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |

## Verification
Each line passes through two synchronizer flops and one edge flop, so the port reacts to a bus edge three system clocks after the bench makes it. A pull on SDA or SCL follows one cycle later, and `irq` one more. The bench master holds every SCL phase for ten clocks and samples SDA in the middle of the high phase, well past those delays. It waits for SCL to read high before it goes on, so stretching is honoured rather than raced. Register effects show on `reg_rdata` in the cycle after the strobe, and interrupt pulses are counted and compared only once the bus is quiet after a stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned DW = 8;

  localparam logic [3:0] MODE_SLV7    = 4'b0110;
  localparam logic [3:0] MODE_SLV7_SS = 4'b1110;

  localparam int unsigned CB_WCOL = 7;
  localparam int unsigned CB_OVF  = 6;
  localparam int unsigned CB_EN   = 5;
  localparam int unsigned CB_CKP  = 4;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DATA = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_AACK = 3'd2,
    ST_RX   = 3'd3,
    ST_RACK = 3'd4,
    ST_TXLD = 3'd5,
    ST_TX   = 3'd6,
    ST_TACK = 3'd7
  } eng_state_e;

  function automatic logic mode_is_slave(input logic [3:0] m);
    return (m == MODE_SLV7) || (m == MODE_SLV7_SS);
  endfunction

  function automatic logic mode_has_ss_irq(input logic [3:0] m);
    return m == MODE_SLV7_SS;
  endfunction

  function automatic logic addr_hit(input logic [DW-1:0] frame, input logic [6:0] own);
    return frame[DW-1:1] == own;
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] prev_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          last  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], async_i[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign level_o[g] = chain[STAGES-1];
      assign prev_o[g]  = last;
    end
  endgenerate
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [DW-1:0] buf_q,
  input  logic          buf_full,
  input  logic          ckp,
  output logic [DW-1:0] rx_byte,
  output logic          rx_push,
  output logic          ovf_evt,
  output logic          byte_done,
  output logic          hold_evt,
  output logic          tx_busy,
  output logic          sda_drive
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_state_e    st, st_n;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shr;
  logic          mack_q;
  logic          rack_ack;

  always_comb begin
    st_n      = st;
    rx_push   = 1'b0;
    ovf_evt   = 1'b0;
    byte_done = 1'b0;
    hold_evt  = 1'b0;
    if (!active) begin
      st_n = ST_IDLE;
    end else if (start_det) begin
      st_n = ST_ADDR;
    end else if (stop_det) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_ADDR: if (scl_fall && cnt == LAST) st_n = addr_hit(shr, OWN_ADDR) ? ST_AACK : ST_IDLE;
        ST_AACK: if (scl_fall) begin
          byte_done = 1'b1;
          if (shr[0]) begin
            st_n     = ST_TXLD;
            hold_evt = 1'b1;
          end else begin
            st_n = ST_RX;
          end
        end
        ST_RX: if (scl_fall && cnt == LAST) begin
          st_n = ST_RACK;
          if (buf_full) ovf_evt = 1'b1;
          else          rx_push = 1'b1;
        end
        ST_RACK: if (scl_fall) begin
          st_n      = ST_RX;
          byte_done = 1'b1;
        end
        ST_TXLD: if (ckp) st_n = ST_TX;
        ST_TX:   if (scl_fall && cnt == LAST) st_n = ST_TACK;
        ST_TACK: if (scl_fall) begin
          byte_done = 1'b1;
          if (mack_q) begin
            st_n     = ST_TXLD;
            hold_evt = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shr      <= '0;
      mack_q   <= 1'b0;
      rack_ack <= 1'b0;
    end else begin
      st <= st_n;
      if (start_det || st_n != st) cnt <= '0;
      else if (scl_rise && (st == ST_ADDR || st == ST_RX || st == ST_TX)) cnt <= cnt + 1'b1;

      if (st == ST_TXLD) shr <= buf_q;
      else if (scl_rise && (st == ST_ADDR || st == ST_RX)) shr <= {shr[DW-2:0], sda_s};
      else if (st == ST_TX && scl_fall && cnt != LAST) shr <= {shr[DW-2:0], 1'b0};

      if (st == ST_TACK && scl_rise) mack_q <= !sda_s;
      if (st == ST_RX && st_n == ST_RACK) rack_ack <= rx_push;
    end
  end

  assign rx_byte   = shr;
  assign tx_busy   = (st == ST_TX) || (st == ST_TACK);
  assign sda_drive = (st == ST_AACK) || (st == ST_RACK && rack_ack) ||
                     ((st == ST_TXLD || st == ST_TX) && !shr[DW-1]);

  AST_RX_ACKED: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> sda_drive); // R6
  AST_OVF_NACKED: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> !sda_drive); // R7
  AST_OFF_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !active |=> (st == ST_IDLE && !sda_drive)); // R11
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) byte_done |-> scl_fall); // R10
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR    = 7'h3A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic          wcol_q, ovf_q, en_q, ckp_q, full_q, irq_q;
  logic [3:0]    mode_q;
  logic [DW-1:0] buf_q;
  logic [1:0]    lvl, prv;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] rx_byte;
  logic          rx_push, ovf_evt, byte_done, hold_evt, tx_busy, sda_drive;
  logic          active, wr_ctrl, wr_data, rd_data, wcol_set, ss_evt;

  i2cs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i({sda_i, scl_i}), .level_o(lvl), .prev_o(prv)
  );

  i2cs_cond i_cond (
    .scl_s(lvl[0]), .scl_p(prv[0]), .sda_s(lvl[1]), .sda_p(prv[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.OWN_ADDR(OWN_ADDR)) i_engine (
    .clk(clk), .rst_n(rst_n), .active(active),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_s(lvl[1]), .buf_q(buf_q), .buf_full(full_q), .ckp(ckp_q),
    .rx_byte(rx_byte), .rx_push(rx_push), .ovf_evt(ovf_evt), .byte_done(byte_done),
    .hold_evt(hold_evt), .tx_busy(tx_busy), .sda_drive(sda_drive)
  );

  assign active   = en_q && mode_is_slave(mode_q);
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_data  = reg_wr && (reg_addr == RA_DATA);
  assign rd_data  = reg_rd && (reg_addr == RA_DATA);
  assign wcol_set = wr_data && tx_busy;
  assign ss_evt   = active && mode_has_ss_irq(mode_q) && (start_det || stop_det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
      en_q   <= 1'b0;
      ckp_q  <= 1'b0;
      mode_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wcol_q <= wcol_q & reg_wdata[CB_WCOL];
        ovf_q  <= ovf_q & reg_wdata[CB_OVF];
        en_q   <= reg_wdata[CB_EN];
        ckp_q  <= reg_wdata[CB_CKP];
        mode_q <= reg_wdata[3:0];
      end
      if (wcol_set) wcol_q <= 1'b1;
      if (ovf_evt)  ovf_q  <= 1'b1;
      if (hold_evt) ckp_q  <= 1'b0;

      if (rx_push)                  buf_q <= rx_byte;
      else if (wr_data && !tx_busy) buf_q <= reg_wdata;

      if (rx_push)      full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      irq_q <= byte_done || ss_evt;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {wcol_q, ovf_q, en_q, ckp_q, mode_q};
      RA_DATA: reg_rdata = buf_q;
      RA_STAT: reg_rdata = {{(DW-1){1'b0}}, full_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq    = irq_q;
  assign scl_oe = active && !ckp_q;
  assign sda_oe = active && sda_drive;

  AST_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> (!scl_oe && !sda_oe)); // R2
  AST_FLAG_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && !wcol_q && !ovf_q && !ovf_evt) |=> (!wcol_q && !ovf_q)); // R3
  AST_FULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> full_q); // R6
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_q) |-> $past(full_q)); // R7
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) hold_evt |=> scl_oe); // R8
  AST_WCOL_TX_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(wcol_q) |-> $past(tx_busy)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R10
endmodule

// File: tb/test_i2cs_port.sv
`timescale 1ns/1ps
module test_i2cs_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  wire        scl = scl_m & ~scl_oe;
  wire        sda = sda_m & ~sda_oe;
  int         checks = 0, fails = 0, irq_cnt = 0;

  localparam logic [6:0] OWN = 7'h3A;
  localparam int NV = 5;
  // entry: {address[6:0], data[7:0], expected acknowledge}
  localparam logic [15:0] RXV [NV] = '{
    {7'h3A, 8'hA5, 1'b1}, {7'h3B, 8'h5A, 1'b0}, {7'h3A, 8'h00, 1'b1},
    {7'h1D, 8'hFF, 1'b0}, {7'h3A, 8'hFF, 1'b1}};

  always #4 clk = ~clk;

  i2cs_port #(.OWN_ADDR(OWN)) i_i2cs_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (scl !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_scl_high(); wcyc(10);
    sda_m = 1'b0; wcyc(10); scl_m = 1'b0; wcyc(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wcyc(10); scl_m = 1'b1; wait_scl_high(); wcyc(10);
    sda_m = 1'b1; wcyc(20);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b; wcyc(10); scl_m = 1'b1; wait_scl_high(); wcyc(5);
    s = sda; wcyc(5); scl_m = 1'b0; wcyc(10);
  endtask

  task automatic byte_write(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    ack = !s;
  endtask

  task automatic byte_read(input logic ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); d[i] = s; end
    bit_xfer(!ack, s);
  endtask

  initial begin
    logic [7:0] r, rb;
    logic       ak;
    int         base;
    wcyc(5); rst_n = 1'b1; wcyc(3);
    // R1 reset state
    reg_read(2'd0, r); chk("R1 ctrl", r, 8'h00);
    reg_read(2'd1, r); chk("R1 data", r, 8'h00);
    reg_read(2'd2, r); chk("R1 status", r, 8'h00);
    chk("R1 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    // R3 flags cannot be set by writing 1
    reg_write(2'd0, 8'hF6); reg_read(2'd0, r); chk("R3 flags write-1", r, 8'h36);
    // R12 software clock stretch
    reg_write(2'd0, 8'h26); wcyc(2); chk("R12 hold", {7'd0, scl}, 8'h00);
    reg_write(2'd0, 8'h36); wcyc(2); chk("R12 release", {7'd0, scl}, 8'h01);

    // R5/R6/R10 vector table, mode 0110
    for (int v = 0; v < NV; v++) begin
      base = irq_cnt;
      bus_start();
      byte_write({RXV[v][15:9], 1'b0}, ak);
      chk("R5 address ack", {7'd0, ak}, {7'd0, RXV[v][0]});
      if (RXV[v][0]) begin
        byte_write(RXV[v][8:1], ak);
        chk("R6 data ack", {7'd0, ak}, 8'h01);
      end
      bus_stop();
      if (RXV[v][0]) begin
        reg_read(2'd2, r); chk("R6 full set", r, 8'h01);
        reg_read(2'd1, r); chk("R6 data", r, RXV[v][8:1]);
        reg_read(2'd2, r); chk("R6 full cleared", r, 8'h00);
      end
      chk("R10 irq count", 8'(irq_cnt - base), RXV[v][0] ? 8'd2 : 8'd0);
    end

    // R4 start/stop interrupts
    reg_write(2'd0, 8'h3E); base = irq_cnt;
    bus_start(); bus_stop(); wcyc(5);
    chk("R4 mode 1110 start+stop", 8'(irq_cnt - base), 8'd2);
    reg_write(2'd0, 8'h36); base = irq_cnt;
    bus_start(); bus_stop(); wcyc(5);
    chk("R4 mode 0110 no pulse", 8'(irq_cnt - base), 8'd0);

    // R9 receive side, then R7 overflow
    bus_start(); byte_write({OWN, 1'b0}, ak);
    reg_write(2'd1, 8'h99); reg_read(2'd0, r); chk("R9 no wcol in rx", r, 8'h36);
    byte_write(8'h11, ak); chk("R7 first ack", {7'd0, ak}, 8'h01);
    byte_write(8'h22, ak); chk("R7 nack on overflow", {7'd0, ak}, 8'h00);
    bus_stop();
    reg_read(2'd0, r); chk("R7 ovf flag", r, 8'h76);
    reg_read(2'd1, r); chk("R7 buffer kept", r, 8'h11);
    reg_write(2'd0, 8'h36); reg_read(2'd0, r); chk("R3 flag clear", r, 8'h36);

    // R8/R9 transmit
    base = irq_cnt;
    bus_start(); byte_write({OWN, 1'b1}, ak); chk("R5 read addr ack", {7'd0, ak}, 8'h01);
    wcyc(10);
    reg_read(2'd0, r); chk("R8 ckp auto clear", r, 8'h26);
    chk("R8 scl held", {7'd0, scl}, 8'h00);
    reg_write(2'd1, 8'hC3); reg_write(2'd0, 8'h36);
    fork
      byte_read(1'b1, rb);
      begin wcyc(60); reg_write(2'd1, 8'h5A); end
    join
    chk("R8 tx byte", rb, 8'hC3);
    wcyc(10);
    reg_read(2'd0, r); chk("R9 wcol set, ckp cleared", r, 8'hA6);
    reg_read(2'd1, r); chk("R9 write dropped", r, 8'hC3);
    reg_write(2'd0, 8'h26); reg_read(2'd0, r); chk("R3 wcol clear", r, 8'h26);
    reg_write(2'd1, 8'h3C); reg_write(2'd0, 8'h36);
    byte_read(1'b0, rb); chk("R8 second tx byte", rb, 8'h3C);
    bus_stop();
    chk("R10 tx irq count", 8'(irq_cnt - base), 8'd3);

    // R2 disabled
    reg_write(2'd0, 8'h16); base = irq_cnt;
    bus_start(); byte_write({OWN, 1'b0}, ak); chk("R2 no ack when off", {7'd0, ak}, 8'h00);
    bus_stop(); chk("R2 no irq when off", 8'(irq_cnt - base), 8'd0);
    // R11 reserved modes
    reg_write(2'd0, 8'h37); base = irq_cnt;
    bus_start(); byte_write({OWN, 1'b0}, ak); chk("R11 mode 0111 no ack", {7'd0, ak}, 8'h00);
    bus_stop();
    reg_write(2'd0, 8'h3F);
    bus_start(); bus_stop();
    chk("R11 mode 1111 no irq", 8'(irq_cnt - base), 8'd0);
    chk("R11 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
    summary();
  end
endmodule